// File: doc/BRIEF.md
# Single-Cycle RISC-V Subset Core

This block is a small single-cycle processor for a narrow RISC-V integer subset. Every enabled clock cycle it fetches one word from a built-in instruction ROM, decodes it, reads up to two source registers, runs the ALU and writes the result back. The program counter also moves on in that same cycle. The supported operations are addi (which also covers li), add, sub, mul, sll, srl, jal and jalr (which also covers ret).

A select input chooses one of four programs that are fixed in the RTL. The core stops when it fetches the unimp word and raises a done flag. Three architectural registers (a0, a1, a2) are brought out so a host or a bench can read the results. A synchronous clear puts the program counter back to zero and leaves the register contents as they are. An enable input gates all progress.

Top module: `mcore_top`

## Requirements
- R1: After the active-low asynchronous reset rst_ni, the PC is zero, every register reads zero, a0_o/a1_o/a2_o are 0 and done_o is 0.
- R2: Register x0 always reads zero. A write to x0 (for example addi x0,x0,5) changes no visible register.
- R3: addi (opcode 0010011, funct3 000) adds the sign-extended 12-bit immediate to rs1. addi rd,x0,-1 gives 0xFFFFFFFF.
- R4: add and sub (opcode 0110011, funct3 000, funct7 0000000 for add and 0100000 for sub) write rs1+rs2 and rs1-rs2.
- R5: mul (opcode 0110011, funct3 000, funct7 0000001) writes the low XLEN bits of rs1*rs2.
- R6: sll (funct3 001) and srl (funct3 101), both with funct7 0000000, shift rs1 logically by rs2[4:0].
- R7: jal (opcode 1101111) writes PC+4 to rd and moves the PC to PC plus the sign-extended J-type offset.
- R8: jalr (opcode 1100111, funct3 000) writes PC+4 to rd and moves the PC to (rs1+imm) with bit 0 cleared. ret is jalr x0,0(x1).
- R9: When the fetched word is 0xC0001073, done_o is 1, the PC holds and no register is written. The same word is supplied for any PC outside the ROM.
- R10: The PC advances by 4 (or jumps) and a register is written only in cycles where en_i=1, clr_i=0 and done_o=0. With en_i=0 the state holds.
- R11: clr_i=1 loads the PC with zero at the next edge and takes priority over en_i. No register is written in that cycle and the register contents are kept.
- R12: prog_i selects the program. Program 0 ends with a0=1, a1=2, a2=3 after 3 instructions. Program 1 ends with a0=3, a1=2 after a call/return (5 instructions). Program 2 ends with a0=0x1FFFFFFF, a1=0xFFFFFFBB, a2=72 (8 instructions). Program 3 ends with a0=0, a1=1, a2=16 after a jalr to an odd target (5 instructions).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute enable |
| clr_i | input | 1 | Synchronous PC clear |
| prog_i | input | PROG_W | Built-in program select |
| a0_o | output | XLEN | Register x10 |
| a1_o | output | XLEN | Register x11 |
| a2_o | output | XLEN | Register x12 |
| done_o | output | 1 | Halt word fetched |

## Verification
The bench uses the default parameters: XLEN=32, PC_W=64, PROG_W=2 and 16 ROM words per program. With a 32-bit datapath, the all-ones result of addi -1, the srl of that value and a negative sub result can all be compared directly with 32-bit constants. The 2-bit select reaches all four programs. Those programs cover the call/return path, a jalr to an odd target and a write to x0. The 64-bit PC means that jal and jalr targets are extended across the full counter width.

// File: rtl/mcore_pkg.sv
package mcore_pkg;

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_OP    = 7'b0110011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [31:0] HALT_WORD = 32'hC0001073;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef struct packed {
    logic    rf_we;
    logic    src_imm;
    logic    jal;
    logic    jalr;
    logic    halt;
    alu_op_e alu_op;
  } ctl_t;

  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                        logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [31:0] enc_j(logic [20:0] off, logic [4:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/mcore_rom.sv
module mcore_rom
  import mcore_pkg::*;
#(
  parameter int PROG_W = 2,
  parameter int AW     = 4
) (
  input  logic [PROG_W-1:0] prog_i,
  input  logic [AW-1:0]     addr_i,
  output logic [31:0]       instr_o
);
  localparam logic [4:0] X0 = 5'd0, RA = 5'd1, T1 = 5'd6;
  localparam logic [4:0] A0 = 5'd10, A1 = 5'd11, A2 = 5'd12;
  localparam logic [6:0] F7_BASE = 7'b0000000, F7_SUB = 7'b0100000, F7_MUL = 7'b0000001;

  always_comb begin
    instr_o = HALT_WORD;
    case (int'(prog_i))
      0: case (int'(addr_i))
        0: instr_o = enc_i(12'd1, X0, 3'b000, A0, OPC_OPIMM);
        1: instr_o = enc_i(12'd2, X0, 3'b000, A1, OPC_OPIMM);
        2: instr_o = enc_r(F7_BASE, A1, A0, 3'b000, A2);
        default: instr_o = HALT_WORD;
      endcase
      1: case (int'(addr_i))
        0: instr_o = enc_i(12'd1, X0, 3'b000, A0, OPC_OPIMM);
        1: instr_o = enc_i(12'd2, X0, 3'b000, A1, OPC_OPIMM);
        2: instr_o = enc_j(21'd8, RA);
        4: instr_o = enc_r(F7_BASE, A1, A0, 3'b000, A0);
        5: instr_o = enc_i(12'd0, RA, 3'b000, X0, OPC_JALR);
        default: instr_o = HALT_WORD;
      endcase
      2: case (int'(addr_i))
        0: instr_o = enc_i(12'hFFF, X0, 3'b000, A0, OPC_OPIMM);
        1: instr_o = enc_i(12'd3, X0, 3'b000, A1, OPC_OPIMM);
        2: instr_o = enc_r(F7_MUL, A1, A1, 3'b000, A2);
        3: instr_o = enc_r(F7_BASE, A1, A2, 3'b001, A2);
        4: instr_o = enc_r(F7_BASE, A1, A0, 3'b101, A0);
        5: instr_o = enc_r(F7_SUB, A2, A1, 3'b000, A1);
        6: instr_o = enc_i(12'd5, X0, 3'b000, X0, OPC_OPIMM);
        7: instr_o = enc_r(F7_BASE, X0, A2, 3'b000, A2);
        default: instr_o = HALT_WORD;
      endcase
      3: case (int'(addr_i))
        0: instr_o = enc_i(12'd1, X0, 3'b000, A0, OPC_OPIMM);
        1: instr_o = enc_i(12'd1, X0, 3'b000, A1, OPC_OPIMM);
        2: instr_o = enc_i(12'd21, X0, 3'b000, T1, OPC_OPIMM);
        3: instr_o = enc_i(12'd0, T1, 3'b000, A2, OPC_JALR);
        4: instr_o = enc_i(12'd9, X0, 3'b000, A1, OPC_OPIMM);
        5: instr_o = enc_r(F7_SUB, A1, A0, 3'b000, A0);
        default: instr_o = HALT_WORD;
      endcase
      default: instr_o = HALT_WORD;
    endcase
  end
endmodule

// File: rtl/mcore_decode.sv
module mcore_decode
  import mcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output ctl_t            ctl_o,
  output logic [XLEN-1:0] imm_o,
  output logic [4:0]      rs1_o,
  output logic [4:0]      rs2_o,
  output logic [4:0]      rd_o
);
  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [11:0] imm_i;
  logic [20:0] imm_j;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign f7    = instr_i[31:25];
  assign rd_o  = instr_i[11:7];
  assign rs1_o = instr_i[19:15];
  assign rs2_o = instr_i[24:20];
  assign imm_i = instr_i[31:20];
  assign imm_j = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};

  always_comb begin
    imm_o = (opc == OPC_JAL) ? XLEN'($signed(imm_j)) : XLEN'($signed(imm_i));
  end

  always_comb begin
    ctl_o = '0;
    ctl_o.alu_op = ALU_ADD;
    if (instr_i == HALT_WORD) begin
      ctl_o.halt = 1'b1;
    end else begin
      case (opc)
        OPC_OPIMM: if (f3 == 3'b000) begin
          ctl_o.rf_we   = 1'b1;
          ctl_o.src_imm = 1'b1;
        end
        OPC_OP: begin
          ctl_o.rf_we = 1'b1;
          case ({f7, f3})
            {7'b0000000, 3'b000}: ctl_o.alu_op = ALU_ADD;
            {7'b0100000, 3'b000}: ctl_o.alu_op = ALU_SUB;
            {7'b0000001, 3'b000}: ctl_o.alu_op = ALU_MUL;
            {7'b0000000, 3'b001}: ctl_o.alu_op = ALU_SLL;
            {7'b0000000, 3'b101}: ctl_o.alu_op = ALU_SRL;
            default:              ctl_o.rf_we  = 1'b0;
          endcase
        end
        OPC_JAL: begin
          ctl_o.rf_we = 1'b1;
          ctl_o.jal   = 1'b1;
        end
        OPC_JALR: if (f3 == 3'b000) begin
          ctl_o.rf_we   = 1'b1;
          ctl_o.jalr    = 1'b1;
          ctl_o.src_imm = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcore_alu.sv
module mcore_alu
  import mcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int SHW = $clog2(XLEN);
  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_MUL: y_o = a_i * b_i;
      ALU_SLL: y_o = a_i << sh;
      ALU_SRL: y_o = a_i >> sh;
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/mcore_regfile.sv
module mcore_regfile #(
  parameter int XLEN     = 32,
  parameter int NREG     = 32,
  parameter int NTAP     = 3,
  parameter int TAP_BASE = 10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [$clog2(NREG)-1:0]   ra1_i,
  input  logic [$clog2(NREG)-1:0]   ra2_i,
  output logic [XLEN-1:0]           rd1_o,
  output logic [XLEN-1:0]           rd2_o,
  input  logic                      we_i,
  input  logic [$clog2(NREG)-1:0]   wa_i,
  input  logic [XLEN-1:0]           wd_i,
  output logic [NTAP-1:0][XLEN-1:0] tap_o
);
  logic [XLEN-1:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  assign rd1_o = (ra1_i == '0) ? '0 : mem_q[ra1_i];
  assign rd2_o = (ra2_i == '0) ? '0 : mem_q[ra2_i];

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap_o[g] = mem_q[TAP_BASE + g];
  end
endmodule

// File: rtl/mcore_top.sv
module mcore_top
  import mcore_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int PC_W    = 64,
  parameter int PROG_W  = 2,
  parameter int ROM_AW  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [PROG_W-1:0] prog_i,
  output logic [XLEN-1:0]   a0_o,
  output logic [XLEN-1:0]   a1_o,
  output logic [XLEN-1:0]   a2_o,
  output logic              done_o
);
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  logic [PC_W-1:0] pc_q, pc_nxt, pc_plus4, imm_pc, jalr_tgt;
  logic [31:0] rom_word, instr;
  logic        fetch_ok, step, rf_we;
  ctl_t        ctl;
  logic [XLEN-1:0] imm, rs1_v, rs2_v, alu_b, alu_y, wd;
  logic [4:0]  rs1, rs2, rd;
  logic [2:0][XLEN-1:0] taps;

  mcore_rom #(.PROG_W(PROG_W), .AW(ROM_AW)) u_rom (
    .prog_i(prog_i), .addr_i(pc_q[ROM_AW+1:2]), .instr_o(rom_word)
  );

  // outside the ROM window or misaligned: treat as halt
  assign fetch_ok = ((pc_q >> (ROM_AW + 2)) == '0) && (pc_q[1:0] == 2'b00);
  assign instr    = fetch_ok ? rom_word : HALT_WORD;

  mcore_decode #(.XLEN(XLEN)) u_dec (
    .instr_i(instr), .ctl_o(ctl), .imm_o(imm),
    .rs1_o(rs1), .rs2_o(rs2), .rd_o(rd)
  );

  mcore_regfile #(.XLEN(XLEN), .NREG(NREG), .NTAP(3), .TAP_BASE(10)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ra1_i(RAW'(rs1)), .ra2_i(RAW'(rs2)), .rd1_o(rs1_v), .rd2_o(rs2_v),
    .we_i(rf_we), .wa_i(RAW'(rd)), .wd_i(wd), .tap_o(taps)
  );

  assign alu_b = ctl.src_imm ? imm : rs2_v;

  mcore_alu #(.XLEN(XLEN)) u_alu (
    .op_i(ctl.alu_op), .a_i(rs1_v), .b_i(alu_b), .y_o(alu_y)
  );

  assign step     = en_i & ~clr_i & ~ctl.halt;
  assign rf_we    = step & ctl.rf_we;
  assign pc_plus4 = pc_q + PC_W'(4);
  assign imm_pc   = PC_W'($signed(imm));
  assign jalr_tgt = PC_W'(alu_y) & ~PC_W'(1);
  assign wd       = (ctl.jal | ctl.jalr) ? XLEN'(pc_plus4) : alu_y;

  always_comb begin
    if (ctl.jal)       pc_nxt = pc_q + imm_pc;
    else if (ctl.jalr) pc_nxt = jalr_tgt;
    else               pc_nxt = pc_plus4;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (clr_i)  pc_q <= '0;
    else if (step)   pc_q <= pc_nxt;
  end

  assign a0_o   = taps[0];
  assign a1_o   = taps[1];
  assign a2_o   = taps[2];
  assign done_o = ctl.halt;
endmodule

// File: rtl/mcore_chk.sv
module mcore_chk #(
  parameter int PC_W = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            clr_i,
  input logic            done_i,
  input logic            we_i,
  input logic            jump_i,
  input logic [PC_W-1:0] pc_i
);
  AST_CLR_ZERO_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pc_i == '0)); // R11
  AST_CLR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !we_i); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(pc_i)); // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !we_i); // R10
  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !done_i && !jump_i) |=> (pc_i == $past(pc_i) + PC_W'(4))); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !clr_i) |=> ($stable(pc_i) && done_i)); // R9
  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !we_i); // R9
endmodule

bind mcore_top mcore_chk #(.PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .clr_i(clr_i),
  .done_i(done_o), .we_i(rf_we), .jump_i(ctl.jal | ctl.jalr), .pc_i(pc_q)
);

// File: tb/sim_mcore_top.sv
module sim_mcore_top;
  localparam int XLEN = 32;
  localparam int PROG_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, clr = 1'b0;
  logic [PROG_W-1:0] prog = '0;
  logic [XLEN-1:0] a0, a1, a2;
  logic done;
  int checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  mcore_top #(.XLEN(XLEN), .PC_W(64), .PROG_W(PROG_W), .ROM_AW(4)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .clr_i(clr), .prog_i(prog),
    .a0_o(a0), .a1_o(a1), .a2_o(a2), .done_o(done)
  );

  typedef struct packed {
    logic [1:0]  prog;
    logic [7:0]  cyc;
    logic [31:0] a0, a1, a2;
  } vec_t;

  // R12 program table: select, instructions to halt, final a0/a1/a2
  localparam vec_t VECS [4] = '{
    '{2'd0, 8'd3, 32'd1,         32'd2,         32'd3},
    '{2'd1, 8'd5, 32'd3,         32'd2,         32'd0},
    '{2'd2, 8'd8, 32'h1FFFFFFF,  32'hFFFFFFBB,  32'd72},
    '{2'd3, 8'd5, 32'd0,         32'd1,         32'd16}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    en = 1'b0; clr = 1'b0;
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
  endtask

  task automatic run_to_done(output int n);
    n = 0;
    en = 1'b1;
    while (!done && n < 64) begin
      @(negedge clk);
      n++;
    end
    en = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state
    do_reset();
    chk("R1 a0", 64'(a0), 64'd0);
    chk("R1 a1", 64'(a1), 64'd0);
    chk("R1 a2", 64'(a2), 64'd0);
    chk("R1 done", 64'(done), 64'd0);

    // R12 table walk (covers R2..R8 through program results)
    for (int i = 0; i < 4; i++) begin
      do_reset();
      prog = VECS[i].prog;
      run_to_done(n);
      chk($sformatf("R12 prog%0d cycles", i), 64'(n), 64'(VECS[i].cyc));
      chk($sformatf("R12 prog%0d a0", i), 64'(a0), 64'(VECS[i].a0));
      chk($sformatf("R12 prog%0d a1", i), 64'(a1), 64'(VECS[i].a1));
      chk($sformatf("R12 prog%0d a2", i), 64'(a2), 64'(VECS[i].a2));
      if (i == 1) chk("R7 R8 call/return a0", 64'(a0), 64'd3);
      if (i == 2) begin
        chk("R3 R6 srl of all-ones", 64'(a0), 64'h1FFFFFFF);
        chk("R4 R2 sub negative, x0 write dropped", 64'(a1), 64'hFFFFFFBB);
        chk("R5 R6 mul then sll", 64'(a2), 64'd72);
      end
      if (i == 3) chk("R8 jalr link and odd target", 64'(a2), 64'd16);
    end

    // R10 enable gating
    do_reset();
    prog = 2'd0;
    repeat (5) @(negedge clk);
    chk("R10 en low a0", 64'(a0), 64'd0);
    chk("R10 en low done", 64'(done), 64'd0);
    en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    chk("R10 single step a0", 64'(a0), 64'd1);
    chk("R10 single step a1", 64'(a1), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 hold a1", 64'(a1), 64'd0);
    run_to_done(n);
    chk("R10 remaining cycles", 64'(n), 64'd2);
    chk("R10 a2", 64'(a2), 64'd3);

    // R9 halt holds
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 done held", 64'(done), 64'd1);
    chk("R9 a2 unchanged", 64'(a2), 64'd3);

    // R11 clear with en high, registers kept
    prog = 2'd1;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    en = 1'b0;
    chk("R11 done cleared", 64'(done), 64'd0);
    chk("R11 a2 kept", 64'(a2), 64'd3);
    chk("R11 a0 kept", 64'(a0), 64'd1);
    run_to_done(n);
    chk("R11 cycles after clear", 64'(n), 64'd5);
    chk("R11 R7 a0", 64'(a0), 64'd3);
    chk("R11 a2 still kept", 64'(a2), 64'd3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule